// File: doc/BRIEF.md
# Causal Sliding-Window Attention Key Generator

This block turns one start pulse into the full list of (query, key) pairs that a causal local-window attention pass has to score. It walks the query positions of a sequence in order. For each query it streams, over a valid/ready handshake, every key position that the query is allowed to see. A flag marks the final key of each query. Score arithmetic and normalisation happen downstream; this block only decides which pairs exist and in what order they arrive.

A query sees the keys from its window start up to and including itself. The window start is the query position minus the window size, clamped at zero. The first few positions of the sequence can be declared global. A global position is visible to every later query, even when it lies far outside that query's window. A query that is itself global sees every earlier position. Each key appears at most once per query, so the cost of a query is bounded by the window plus the global count, not by the sequence length. A single-cycle done pulse closes the pass.

Top module: `swin_mask_gen`

## Requirements
- R1: No emitted key is greater than its query position (causality).
- R2: For query q with effective window W, every key from max(0, q−W) through q is emitted, and a key below max(0, q−W) is emitted only if it is global.
- R3: Positions 0 through G−1 are global (G is `n_global`). A query q < G emits every key 0..q.
- R4: For a query q ≥ G, the global keys below the window start come first, then the window keys. Within a query, keys are strictly ascending with no repeats.
- R5: A `window` value of 0 selects the default window of 256 (parameter `DEFAULT_WINDOW`).
- R6: Queries are served in order 0..L−1, where L is `seq_len`. `out_last` is 1 on exactly one beat per query, the beat whose key equals the query.
- R7: `done` is high for one cycle, in the cycle after the handshake of the final beat of query L−1. With L = 0, `done` rises in the cycle after the start and no beat is emitted. `out_valid` is low whenever `done` is high.
- R8: A `start` that arrives while a pass is running is ignored. The running pass keeps the length, window and global count it started with.
- R9: While `out_valid` is high and `out_ready` is low, the beat (valid, query, key, last) holds unchanged.
- R10: After reset, `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a pass; taken only while idle |
| seq_len | input | 16 | Number of query positions L |
| window | input | 16 | Look-back window W; 0 selects the default |
| n_global | input | 16 | Count G of global leading positions |
| out_valid | output | 1 | A (query, key) beat is offered |
| out_ready | input | 1 | Consumer accepts the offered beat |
| out_query | output | 16 | Query position of the beat |
| out_key | output | 16 | Key position of the beat |
| out_last | output | 1 | Final key of this query |
| done | output | 1 | One-cycle pulse after the last beat of the pass |

## Verification
On every cycle, the assertions check several properties. Keys never pass their query, and every key is either in the window or global. Keys within a query only go up. A stalled beat holds steady. `done` never overlaps a valid beat and only follows a final handshake or an empty pass. A start while busy leaves the latched settings alone. The assertions also check that the bounds computed for the next query match the ones used once the cursor moves there. Only the bench's scenarios can show the following: the exact key list of each query, and that no required key is missing. They also show the order of global keys against window keys, the default-window substitution, the timing of `done` for normal and empty passes, and that a start during a pass does not change the stream.

// File: rtl/swin_pkg.sv
package swin_pkg;

  localparam int unsigned POS_W = 16;
  typedef logic [POS_W-1:0] pos_t;

  // Window size actually applied: zero picks the built-in default.
  function automatic pos_t eff_window(input pos_t w, input pos_t dflt);
    return (w == '0) ? dflt : w;
  endfunction

  // Lowest key inside the look-back window, clamped at position zero.
  function automatic pos_t span_start(input pos_t q, input pos_t w);
    return (q >= w) ? pos_t'(q - w) : '0;
  endfunction

  // Start of the contiguous run for query q: a global query sees all of 0..q.
  function automatic pos_t run_start(input pos_t q, input pos_t w, input pos_t g);
    return (q < g) ? '0 : span_start(q, w);
  endfunction

  // One past the last global key emitted ahead of the contiguous run.
  function automatic pos_t lead_end(input pos_t lo, input pos_t g);
    return (g < lo) ? g : lo;
  endfunction

  // First key of a query: key 0 when a global prefix exists, else the run start.
  function automatic pos_t first_key(input pos_t lo, input pos_t gend);
    return (gend != '0) ? '0 : lo;
  endfunction

  // Successor of key k: jump from the global prefix to the run start.
  function automatic pos_t step_key(input pos_t k, input pos_t lo, input pos_t gend);
    pos_t kn;
    kn = pos_t'(k + 1'b1);
    return (kn == gend) ? lo : kn;
  endfunction

endpackage

// File: rtl/swin_bounds.sv
module swin_bounds
  import swin_pkg::*;
(
  input  pos_t q,
  input  pos_t w_eff,
  input  pos_t g,
  output pos_t lo,
  output pos_t gend,
  output pos_t first
);

  always_comb begin
    lo    = run_start(q, w_eff, g);
    gend  = lead_end(lo, g);
    first = first_key(lo, gend);
  end

endmodule

// File: rtl/swin_key_cursor.sv
module swin_key_cursor
  import swin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic advance,
  input  logic q_step,
  input  pos_t first_nxt,
  input  pos_t lo,
  input  pos_t gend,
  output pos_t key
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key <= '0;
    end else if (load) begin
      key <= '0;
    end else if (advance) begin
      key <= q_step ? first_nxt : step_key(key, lo, gend);
    end
  end

  // Keys within one query strictly increase.
  assert_key_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !q_step && !load) |=> (key > $past(key)));

endmodule

// File: rtl/swin_query_ctl.sv
module swin_query_ctl
  import swin_pkg::*;
#(
  parameter int unsigned DEFAULT_WINDOW = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  pos_t seq_len,
  input  pos_t window,
  input  pos_t n_global,
  input  logic advance,
  input  logic at_last,
  output pos_t q,
  output pos_t w_eff,
  output pos_t g_r,
  output logic running,
  output logic done,
  output logic accept_evt,
  output logic q_step,
  output logic finish_evt
);

  typedef enum logic { S_IDLE, S_RUN } state_t;
  state_t state;
  pos_t   len_r;

  localparam pos_t DFLT_W = pos_t'(DEFAULT_WINDOW);

  assign running    = (state == S_RUN);
  assign accept_evt = start && !running;
  assign q_step     = advance && at_last;
  assign finish_evt = q_step && (q == pos_t'(len_r - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      q     <= '0;
      len_r <= '0;
      w_eff <= '0;
      g_r   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept_evt) begin
        len_r <= seq_len;
        w_eff <= eff_window(window, DFLT_W);
        g_r   <= n_global;
        q     <= '0;
        if (seq_len == '0) done  <= 1'b1;
        else               state <= S_RUN;
      end else if (finish_evt) begin
        state <= S_IDLE;
        done  <= 1'b1;
      end else if (q_step) begin
        q <= pos_t'(q + 1'b1);
      end
    end
  end

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(finish_evt || (accept_evt && seq_len == '0)));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start) |=> (len_r == $past(len_r) && w_eff == $past(w_eff) && g_r == $past(g_r)));

  assert_query_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (q < len_r));

endmodule

// File: rtl/swin_mask_gen.sv
module swin_mask_gen
  import swin_pkg::*;
#(
  parameter int unsigned DEFAULT_WINDOW = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] seq_len,
  input  logic [15:0] window,
  input  logic [15:0] n_global,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_query,
  output logic [15:0] out_key,
  output logic        out_last,
  output logic        done
);

  localparam int unsigned NB = 2; // bounds for the current and the next query

  pos_t q, w_eff, g_r, key;
  logic running, accept_evt, q_step, finish_evt;
  logic hs, at_last;

  pos_t bq    [NB];
  pos_t lo_a  [NB];
  pos_t gend_a[NB];
  pos_t first_a[NB];

  assign bq[0] = q;
  assign bq[1] = pos_t'(q + 1'b1);

  for (genvar i = 0; i < NB; i++) begin : g_bounds
    swin_bounds u_bounds (
      .q     (bq[i]),
      .w_eff (w_eff),
      .g     (g_r),
      .lo    (lo_a[i]),
      .gend  (gend_a[i]),
      .first (first_a[i])
    );
  end

  assign hs      = running && out_ready;
  assign at_last = (key == q);

  swin_query_ctl #(.DEFAULT_WINDOW(DEFAULT_WINDOW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .seq_len    (seq_len),
    .window     (window),
    .n_global   (n_global),
    .advance    (hs),
    .at_last    (at_last),
    .q          (q),
    .w_eff      (w_eff),
    .g_r        (g_r),
    .running    (running),
    .done       (done),
    .accept_evt (accept_evt),
    .q_step     (q_step),
    .finish_evt (finish_evt)
  );

  swin_key_cursor u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_evt),
    .advance   (hs),
    .q_step    (q_step),
    .first_nxt (first_a[1]),
    .lo        (lo_a[0]),
    .gend      (gend_a[0]),
    .key       (key)
  );

  assign out_valid = running;
  assign out_query = q;
  assign out_key   = key;
  assign out_last  = at_last;

  assert_causal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_key <= out_query));

  assert_key_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((key >= lo_a[0]) || (key < gend_a[0])));

  assert_next_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_step && !finish_evt) |=> (lo_a[0] == $past(lo_a[1]) && gend_a[0] == $past(gend_a[1])
                                 && key == first_a[0]));

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_query)
                                   && $stable(out_last)));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/swin_mask_gen_tb_top.sv
module swin_mask_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] seq_len = '0;
  logic [15:0] window = '0;
  logic [15:0] n_global = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_query;
  logic [15:0] out_key;
  logic        out_last;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  swin_mask_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_len(seq_len), .window(window),
    .n_global(n_global), .out_valid(out_valid), .out_ready(out_ready),
    .out_query(out_query), .out_key(out_key), .out_last(out_last), .done(done)
  );

  // {L, W, G, ready mode}
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    64'h0008_0003_0000_0000,  // plain window, always ready
    64'h000C_0002_0003_0001,  // globals ahead of a narrow window, stalls
    64'h000A_0004_000A_0000,  // every query global
    64'h0001_0005_0000_0002,  // single query
    64'h0010_0001_0002_0001,  // window of one
    64'h0009_0014_0001_0002,  // window wider than the sequence
    64'h0006_0000_0000_0001,  // default window
    64'h0014_0005_0007_0002   // mixed, irregular stalls
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Independent statement of visibility from the requirements.
  function automatic bit visible(input int q, input int k, input int w, input int g);
    int we;
    we = (w == 0) ? 256 : w;
    return (k <= q) && ((k < g) || (q < g) || (k + we >= q));
  endfunction

  function automatic int count_pairs(input int l, input int w, input int g);
    int n = 0;
    for (int q = 0; q < l; q++)
      for (int k = 0; k <= q; k++)
        if (visible(q, k, w, g)) n++;
    return n;
  endfunction

  function automatic bit ready_at(input int mode, input int cyc);
    case (mode)
      1:       return (cyc % 3) != 0;
      2:       return (cyc % 5) >= 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic pulse_start(input int l, input int w, input int g);
    @(negedge clk);
    seq_len = 16'(l); window = 16'(w); n_global = 16'(g); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Walk one pass; optionally fire a second start mid-pass.
  task automatic run_pass(input int l, input int w, input int g, input int mode,
                          input string req, input bit busy_poke);
    int eq = 0, ek = 0, beats = 0, cyc = 0;
    bit fin = 0, held = 0;
    logic [15:0] hq = '0, hk = '0;
    logic hl = 1'b0;
    pulse_start(l, w, g);
    if (l == 0) begin
      check(done === 1'b1, "R7", "done after empty start", int'(done), 1);
      check(out_valid === 1'b0, "R7", "no beat for empty pass", int'(out_valid), 0);
      @(negedge clk);
      check(done === 1'b0, "R7", "done width", int'(done), 0);
      return;
    end
    while (!fin && cyc < 5000) begin
      out_ready = ready_at(mode, cyc);
      if (busy_poke && cyc == 3) begin
        seq_len = 16'd30; window = 16'd9; n_global = 16'd4; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (held)
        check(out_valid && out_query == hq && out_key == hk && out_last == hl,
              "R9", "beat held under stall", int'(out_key), int'(hk));
      held = 0;
      if (done) check(1'b0, "R7", "done before final beat", 1, 0);
      if (out_valid && out_ready) begin
        check(out_query == 16'(eq) && out_key == 16'(ek), req, "key",
              int'(out_key), ek);
        check(out_query == 16'(eq), "R6", "query", int'(out_query), eq);
        check(out_last == (ek == eq), "R6", "last flag", int'(out_last), int'(ek == eq));
        check(out_key <= out_query, "R1", "causal", int'(out_key), eq);
        beats++;
        if (ek == eq && eq == l - 1) begin
          fin = 1;
        end else begin
          int k = ek + 1;
          while (k <= eq && !visible(eq, k, w, g)) k++;
          if (k > eq) begin
            eq++;
            k = 0;
            while (!visible(eq, k, w, g)) k++;
          end
          ek = k;
        end
      end else if (out_valid) begin
        held = 1; hq = out_query; hk = out_key; hl = out_last;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    check(beats == count_pairs(l, w, g), "R2", "beat count", beats, count_pairs(l, w, g));
    check(done === 1'b1 && out_valid === 1'b0, "R7", "done after final beat", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R7", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", "valid in reset", int'(out_valid), 0);
    check(done === 1'b0, "R10", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0, "R10", "idle after reset", int'(out_valid), 0);

    for (int i = 0; i < NV; i++) begin
      int l, w, g, m;
      string req;
      l = int'(VEC[i][63:48]); w = int'(VEC[i][47:32]);
      g = int'(VEC[i][31:16]); m = int'(VEC[i][15:0]);
      req = (w == 0) ? "R5" : (g >= l) ? "R3" : (g > 0) ? "R4" : "R2";
      run_pass(l, w, g, m, req, 1'b0);
    end

    // Empty sequence.
    run_pass(0, 4, 0, 0, "R7", 1'b0);
    // Start during a running pass must not disturb it.
    run_pass(5, 2, 0, 1, "R8", 1'b1);
    // Query equal to G boundary with a zero-width-like window of one.
    run_pass(6, 1, 3, 0, "R4", 1'b0);

    // Reset in mid-pass.
    pulse_start(10, 3, 0);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0, "R10", "reset mid-pass", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10", "stays idle", int'(out_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule